// File: doc/BRIEF.md
# Transport-Addressed Multiplexer Interconnect

This block is the switch network between the units of a transport-programmed datapath. Each instruction word carries several move slots that run in the same cycle. A slot names a source port and a destination port in one shared port address space, and it carries a control byte for each of those two ports. The block decodes every slot and fetches the word from the addressed source. It presents that word, with a write strobe and the destination control byte, on the addressed destination lane. The source port gets a read strobe and its own control byte, for example a register number.

All routing is done with multiplexers. No tristate bus is used. Each port has a write-side selector that picks among the slots addressing it as a destination. Each port also has a read-side selector that picks among the slots addressing it as a source. When two valid slots name the same destination, the lower-numbered slot is delivered and a conflict flag is raised. When any valid slot names a source that is not ready, `stall` goes high in the same cycle. The whole instruction is then withheld: no strobe of any slot is issued. The fetch side must present the same word again until `stall` drops.

Top module: `xbar_interconnect`

## Requirements
- R1: While `rst` is high at a clock edge, `dst_we`, `src_rd`, `conflict` and every lane of `dst_data`, `dst_ctrl` and `src_ctrl` read zero after that edge.
- R2: A slot occupies `instr[s*25 +: 25]`. Within a slot, bit 24 is valid, bits 23:20 are the source address, bits 19:16 are the destination address, bits 15:8 are the source control and bits 7:0 are the destination control. Lane p of a wide bus is `[p*W +: W]`. For an issued valid slot, one clock later `dst_we[dst]` is 1 and lane dst of `dst_data` equals lane src of `src_data` as sampled at the issue edge.
- R3: For an issued valid slot, one clock later lane dst of `dst_ctrl` holds the destination control, `src_rd[src]` is 1, and lane src of `src_ctrl` holds the source control.
- R4: Both slots of one word are delivered in the same cycle when their destinations differ.
- R5: A slot with its valid bit at 0 causes no strobe, no lane value and no stall, whatever its other fields hold.
- R6: When both valid slots name the same destination, that lane carries slot 0's data and control, and `conflict` is 1 one clock later. Otherwise `conflict` is 0.
- R7: `stall` is 1 in the same cycle whenever a valid slot names a source whose `src_ready` bit is 0. On the following clock, `dst_we` and `src_rd` are all zero and `conflict` is 0.
- R8: When both valid slots name the same source, both destinations receive that source's word. The source gets one read strobe, and its control lane holds slot 0's source control.
- R9: Lanes of `dst_data`, `dst_ctrl` and `src_ctrl` whose strobe is 0 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr | input | 50 | Instruction word holding two move slots |
| src_data | input | 256 | Output words of all 16 ports, lane per port |
| src_ready | input | 16 | Per-port flag that the port's output word is valid |
| stall | output | 1 | Same-cycle request to hold the present instruction |
| dst_we | output | 16 | Per-port write strobe, registered |
| dst_data | output | 256 | Per-port delivered word, registered |
| dst_ctrl | output | 128 | Per-port destination control byte, registered |
| src_rd | output | 16 | Per-port read strobe, registered |
| src_ctrl | output | 128 | Per-port source control byte, registered |
| conflict | output | 1 | Two valid slots shared a destination, registered |

## Verification
`stall` is combinational, so the bench reads it one time unit after it drives a word, inside the same cycle. All other outputs are registered and are due one clock after the word is driven. For each word, the driver pushes one expected record into a queue at the falling edge. The monitor pops that record just after the next rising edge and compares every strobe and every lane, the zero lanes included. Each record thus meets the edge that produced it, and never a later one. The reset check raises `rst` while a writing word is presented, then inspects the outputs just after the following edge.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  localparam int XB_NSLOT = 2;
  localparam int XB_AW    = 4;
  localparam int XB_DW    = 16;
  localparam int XB_CW    = 8;

  // bits in one move slot: valid, source, destination, two control fields
  function automatic int slot_bits(int aw, int cw);
    return 1 + 2 * aw + 2 * cw;
  endfunction
endpackage

// File: rtl/xbar_slot_decode.sv
module xbar_slot_decode #(
  parameter int AW = 4,
  parameter int DW = 16,
  parameter int CW = 8
) (
  input  logic [xbar_pkg::slot_bits(AW, CW)-1:0] slot,
  input  logic [(1<<AW)*DW-1:0]                  src_data,
  input  logic [(1<<AW)-1:0]                     src_ready,
  output logic [(1<<AW)-1:0]                     src_oh,
  output logic [(1<<AW)-1:0]                     dst_oh,
  output logic [DW-1:0]                          data,
  output logic [CW-1:0]                          sctrl,
  output logic [CW-1:0]                          dctrl,
  output logic                                   blocked
);
  localparam int NPORT = 1 << AW;
  localparam int SW    = xbar_pkg::slot_bits(AW, CW);

  logic          valid;
  logic [AW-1:0] saddr;
  logic [AW-1:0] daddr;

  assign valid = slot[SW-1];
  assign saddr = slot[SW-2 -: AW];
  assign daddr = slot[SW-2-AW -: AW];
  assign sctrl = slot[2*CW-1 -: CW];
  assign dctrl = slot[CW-1:0];

  // read-side select: word from the addressed source
  assign data    = src_data[saddr*DW +: DW];
  assign blocked = valid & ~src_ready[saddr];
  assign src_oh  = valid ? (NPORT'(1) << saddr) : '0;
  assign dst_oh  = valid ? (NPORT'(1) << daddr) : '0;
endmodule

// File: rtl/xbar_prio_pick.sv
module xbar_prio_pick #(
  parameter int NSLOT = 2,
  parameter int W     = 8
) (
  input  logic [NSLOT-1:0]   sel,
  input  logic [NSLOT*W-1:0] vals,
  output logic               hit,
  output logic [W-1:0]       val
);
  // lowest selected slot wins; zero when none is selected
  always_comb begin
    val = '0;
    for (int i = NSLOT - 1; i >= 0; i--) begin
      if (sel[i]) val = vals[i*W +: W];
    end
  end
  assign hit = |sel;
endmodule

// File: rtl/xbar_interconnect.sv
module xbar_interconnect #(
  parameter int NSLOT = xbar_pkg::XB_NSLOT,
  parameter int AW    = xbar_pkg::XB_AW,
  parameter int DW    = xbar_pkg::XB_DW,
  parameter int CW    = xbar_pkg::XB_CW
) (
  input  logic                                        clk,
  input  logic                                        rst,
  input  logic [NSLOT*xbar_pkg::slot_bits(AW,CW)-1:0] instr,
  input  logic [(1<<AW)*DW-1:0]                       src_data,
  input  logic [(1<<AW)-1:0]                          src_ready,
  output logic                                        stall,
  output logic [(1<<AW)-1:0]                          dst_we,
  output logic [(1<<AW)*DW-1:0]                       dst_data,
  output logic [(1<<AW)*CW-1:0]                       dst_ctrl,
  output logic [(1<<AW)-1:0]                          src_rd,
  output logic [(1<<AW)*CW-1:0]                       src_ctrl,
  output logic                                        conflict
);
  localparam int NPORT = 1 << AW;
  localparam int SW    = xbar_pkg::slot_bits(AW, CW);
  localparam int WW    = DW + CW;

  logic [NSLOT-1:0][NPORT-1:0] s_src_oh;
  logic [NSLOT-1:0][NPORT-1:0] s_dst_oh;
  logic [NSLOT-1:0]            s_blk;
  logic [NSLOT*WW-1:0]         s_wval;
  logic [NSLOT*CW-1:0]         s_rval;

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    logic [DW-1:0] data;
    logic [CW-1:0] sctrl;
    logic [CW-1:0] dctrl;
    xbar_slot_decode #(.AW(AW), .DW(DW), .CW(CW)) u_dec (
      .slot(instr[s*SW +: SW]),
      .src_data(src_data),
      .src_ready(src_ready),
      .src_oh(s_src_oh[s]),
      .dst_oh(s_dst_oh[s]),
      .data(data),
      .sctrl(sctrl),
      .dctrl(dctrl),
      .blocked(s_blk[s])
    );
    assign s_wval[s*WW +: WW] = {data, dctrl};
    assign s_rval[s*CW +: CW] = sctrl;
  end

  logic                  issue;
  logic [NPORT-1:0]      we_n;
  logic [NPORT-1:0]      rd_n;
  logic [NPORT-1:0]      multi_n;
  logic [NPORT*DW-1:0]   dd_n;
  logic [NPORT*CW-1:0]   dc_n;
  logic [NPORT*CW-1:0]   sc_n;

  assign stall = |s_blk;
  assign issue = ~stall;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    logic [NSLOT-1:0] wsel;
    logic [NSLOT-1:0] rsel;
    logic [WW-1:0]    wv;
    for (genvar s = 0; s < NSLOT; s++) begin : g_sel
      assign wsel[s] = s_dst_oh[s][p];
      assign rsel[s] = s_src_oh[s][p];
    end
    // write-side selector of destination port p
    xbar_prio_pick #(.NSLOT(NSLOT), .W(WW)) u_wr (
      .sel(wsel), .vals(s_wval), .hit(we_n[p]), .val(wv)
    );
    // read-side selector of source port p
    xbar_prio_pick #(.NSLOT(NSLOT), .W(CW)) u_rd (
      .sel(rsel), .vals(s_rval), .hit(rd_n[p]), .val(sc_n[p*CW +: CW])
    );
    assign dd_n[p*DW +: DW] = wv[WW-1 -: DW];
    assign dc_n[p*CW +: CW] = wv[CW-1:0];
    assign multi_n[p]       = ($countones(wsel) > 1);
  end

  always_ff @(posedge clk) begin
    if (rst || !issue) begin
      dst_we   <= '0;
      dst_data <= '0;
      dst_ctrl <= '0;
      src_rd   <= '0;
      src_ctrl <= '0;
      conflict <= 1'b0;
    end else begin
      dst_we   <= we_n;
      dst_data <= dd_n;
      dst_ctrl <= dc_n;
      src_rd   <= rd_n;
      src_ctrl <= sc_n;
      conflict <= |multi_n;
    end
  end
endmodule

// File: rtl/xbar_checker.sv
module xbar_checker #(
  parameter int NSLOT = 2,
  parameter int AW    = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            stall,
  input logic            s0_valid,
  input logic [AW-1:0]   s0_dst,
  input logic [(1<<AW)-1:0] dst_we,
  input logic [(1<<AW)-1:0] src_rd,
  input logic            conflict
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (dst_we == '0 && src_rd == '0 && !conflict));

  assert_slot0_lands_R2: assert property (@(posedge clk) disable iff (rst)
    (!stall && s0_valid) |=> dst_we[$past(s0_dst)]);

  assert_read_with_write_R3: assert property (@(posedge clk) disable iff (rst)
    ((dst_we != '0) == (src_rd != '0)));

  assert_strobe_bound_R4: assert property (@(posedge clk) disable iff (rst)
    ($countones(dst_we) <= NSLOT && $countones(src_rd) <= NSLOT));

  assert_conflict_merges_R6: assert property (@(posedge clk) disable iff (rst)
    conflict |-> ($countones(dst_we) < NSLOT));

  assert_quiet_after_stall_R7: assert property (@(posedge clk) disable iff (rst)
    stall |=> (dst_we == '0 && src_rd == '0 && !conflict));
endmodule

bind xbar_interconnect xbar_checker #(.NSLOT(NSLOT), .AW(AW)) u_chk (
  .clk(clk),
  .rst(rst),
  .stall(stall),
  .s0_valid(instr[SW-1]),
  .s0_dst(instr[SW-2-AW -: AW]),
  .dst_we(dst_we),
  .src_rd(src_rd),
  .conflict(conflict)
);

// File: tb/tb_xbar_interconnect.sv
module tb_xbar_interconnect;
  localparam int NSLOT = 2;
  localparam int AW    = 4;
  localparam int DW    = 16;
  localparam int CW    = 8;
  localparam int NPORT = 1 << AW;
  localparam int SW    = 1 + 2*AW + 2*CW;
  localparam int IW    = NSLOT * SW;

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic [IW-1:0]       instr = '0;
  logic [NPORT*DW-1:0] src_data = '0;
  logic [NPORT-1:0]    src_ready = '1;
  logic                stall;
  logic [NPORT-1:0]    dst_we;
  logic [NPORT*DW-1:0] dst_data;
  logic [NPORT*CW-1:0] dst_ctrl;
  logic [NPORT-1:0]    src_rd;
  logic [NPORT*CW-1:0] src_ctrl;
  logic                conflict;

  xbar_interconnect #(.NSLOT(NSLOT), .AW(AW), .DW(DW), .CW(CW)) dut (
    .clk(clk), .rst(rst), .instr(instr), .src_data(src_data),
    .src_ready(src_ready), .stall(stall), .dst_we(dst_we),
    .dst_data(dst_data), .dst_ctrl(dst_ctrl), .src_rd(src_rd),
    .src_ctrl(src_ctrl), .conflict(conflict)
  );

  always #5 clk = ~clk;

  typedef struct {
    string               tag;
    logic [NPORT-1:0]    we;
    logic [NPORT*DW-1:0] data;
    logic [NPORT*CW-1:0] dctrl;
    logic [NPORT-1:0]    rd;
    logic [NPORT*CW-1:0] sctrl;
    logic                conf;
    logic                stl;
  } exp_t;

  exp_t exp_q[$];
  int   n_vec = 0;
  int   n_bad = 0;
  bit   done  = 0;

  function automatic logic [SW-1:0] mk(logic v, logic [AW-1:0] sa, logic [AW-1:0] da,
                                       logic [CW-1:0] sc, logic [CW-1:0] dc);
    return {v, sa, da, sc, dc};
  endfunction

  function automatic logic [NPORT*DW-1:0] fill(logic [7:0] seed);
    logic [NPORT*DW-1:0] r;
    for (int p = 0; p < NPORT; p++) r[p*DW +: DW] = {seed, 8'(p)};
    return r;
  endfunction

  function automatic exp_t model(string tag, logic [IW-1:0] ins,
                                 logic [NPORT*DW-1:0] sd, logic [NPORT-1:0] rdy);
    exp_t e;
    logic bad;
    e.tag = tag; e.we = '0; e.data = '0; e.dctrl = '0;
    e.rd = '0; e.sctrl = '0; e.conf = 1'b0;
    bad = 1'b0;
    for (int s = 0; s < NSLOT; s++)
      if (ins[s*SW + SW-1] && !rdy[ins[s*SW + SW-2 -: AW]]) bad = 1'b1;
    e.stl = bad;
    if (!bad) begin
      for (int s = NSLOT - 1; s >= 0; s--) begin
        logic [SW-1:0] f;
        logic [AW-1:0] sa;
        logic [AW-1:0] da;
        f  = ins[s*SW +: SW];
        sa = f[SW-2 -: AW];
        da = f[SW-2-AW -: AW];
        if (f[SW-1]) begin
          e.we[da] = 1'b1;
          e.data[da*DW +: DW]  = sd[sa*DW +: DW];
          e.dctrl[da*CW +: CW] = f[CW-1:0];
          e.rd[sa] = 1'b1;
          e.sctrl[sa*CW +: CW] = f[2*CW-1 -: CW];
        end
      end
      for (int a = 0; a < NSLOT; a++)
        for (int b = a + 1; b < NSLOT; b++)
          if (ins[a*SW+SW-1] && ins[b*SW+SW-1] &&
              ins[a*SW+SW-2-AW -: AW] == ins[b*SW+SW-2-AW -: AW]) e.conf = 1'b1;
    end
    return e;
  endfunction

  task automatic apply(string tag, logic [IW-1:0] ins,
                       logic [NPORT*DW-1:0] sd, logic [NPORT-1:0] rdy);
    exp_t e;
    @(negedge clk);
    instr = ins; src_data = sd; src_ready = rdy;
    e = model(tag, ins, sd, rdy);
    #1;
    n_vec++;
    if (stall !== e.stl) begin
      n_bad++;
      $display("FAIL %s R7 stall actual=%0b expected=%0b", tag, stall, e.stl);
    end
    exp_q.push_back(e);
  endtask

  // monitor: one record per edge, compared just after it
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        exp_t e;
        bit   ok;
        e  = exp_q.pop_front();
        ok = 1;
        n_vec++;
        if (dst_we !== e.we) begin ok = 0;
          $display("FAIL %s dst_we actual=%h expected=%h", e.tag, dst_we, e.we); end
        if (dst_data !== e.data) begin ok = 0;
          $display("FAIL %s dst_data actual=%h expected=%h", e.tag, dst_data, e.data); end
        if (dst_ctrl !== e.dctrl) begin ok = 0;
          $display("FAIL %s dst_ctrl actual=%h expected=%h", e.tag, dst_ctrl, e.dctrl); end
        if (src_rd !== e.rd) begin ok = 0;
          $display("FAIL %s src_rd actual=%h expected=%h", e.tag, src_rd, e.rd); end
        if (src_ctrl !== e.sctrl) begin ok = 0;
          $display("FAIL %s src_ctrl actual=%h expected=%h", e.tag, src_ctrl, e.sctrl); end
        if (conflict !== e.conf) begin ok = 0;
          $display("FAIL %s conflict actual=%0b expected=%0b", e.tag, conflict, e.conf); end
        if (!ok) n_bad++;
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  task automatic check_clear(string tag);
    n_vec++;
    if (dst_we !== '0 || src_rd !== '0 || conflict !== 1'b0 ||
        dst_data !== '0 || dst_ctrl !== '0 || src_ctrl !== '0) begin
      n_bad++;
      $display("FAIL %s R1 outputs actual we=%h rd=%h conf=%0b expected all zero",
               tag, dst_we, src_rd, conflict);
    end
  endtask

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  localparam logic [SW-1:0] NOP = '0;

  initial begin
    repeat (3) @(posedge clk);
    #2 check_clear("R1 initial reset");
    @(negedge clk) rst = 1'b0;

    // R2 R3 single move from port 3 to port 9
    apply("R2 R3 single", {NOP, mk(1, 4'd3, 4'd9, 8'hA5, 8'h3C)}, fill(8'h11), '1);
    // R5 slot 0 invalid with busy-looking fields, slot 1 moves
    apply("R5 slot0 idle", {mk(1, 4'd7, 4'd2, 8'h01, 8'h02), mk(0, 4'd5, 4'd6, 8'hFF, 8'hEE)},
          fill(8'h22), '1);
    // R4 two moves in parallel, R9 other lanes stay zero
    apply("R4 R9 parallel", {mk(1, 4'd1, 4'd4, 8'h44, 8'h55), mk(1, 4'd8, 4'd12, 8'h66, 8'h77)},
          fill(8'h33), '1);
    // R6 shared destination, slot 0 wins
    apply("R6 conflict", {mk(1, 4'd10, 4'd5, 8'h90, 8'h91), mk(1, 4'd11, 4'd5, 8'h80, 8'h81)},
          fill(8'h44), '1);
    // R7 slot 1 source not ready: whole word withheld
    apply("R7 stall", {mk(1, 4'd6, 4'd0, 8'h12, 8'h34), mk(1, 4'd2, 4'd3, 8'h56, 8'h78)},
          fill(8'h55), 16'hFFBF);
    apply("R7 stall held conflict", {mk(1, 4'd6, 4'd1, 8'h12, 8'h34), mk(1, 4'd6, 4'd1, 8'h56, 8'h78)},
          fill(8'h56), 16'hFFBF);
    apply("R7 released", {mk(1, 4'd6, 4'd0, 8'h12, 8'h34), mk(1, 4'd2, 4'd3, 8'h56, 8'h78)},
          fill(8'h57), '1);
    // R8 same source feeds two destinations
    apply("R8 shared source", {mk(1, 4'd9, 4'd14, 8'hC1, 8'hC2), mk(1, 4'd9, 4'd13, 8'hB1, 8'hB2)},
          fill(8'h66), '1);
    // R5 R7 invalid slot naming a not-ready source does not stall
    apply("R5 R7 idle slot busy src", {mk(1, 4'd4, 4'd4, 8'h0F, 8'hF0), mk(0, 4'd15, 4'd0, 8'h99, 8'h98)},
          fill(8'h77), 16'h7FFF);
    // R2 boundary addresses 0 and 15
    apply("R2 R4 edge ports", {mk(1, 4'd15, 4'd0, 8'h5A, 8'hA5), mk(1, 4'd0, 4'd15, 8'h3C, 8'hC3)},
          fill(8'h88), '1);
    // R5 empty word
    apply("R5 empty", '0, fill(8'h99), '0);
    // R6 R7 conflict while stalled reports nothing
    apply("R6 R7 stalled conflict", {mk(1, 4'd1, 4'd7, 8'h10, 8'h20), mk(1, 4'd2, 4'd7, 8'h30, 8'h40)},
          fill(8'hAA), 16'hFFFD);
    apply("R6 conflict issued", {mk(1, 4'd1, 4'd7, 8'h10, 8'h20), mk(1, 4'd2, 4'd7, 8'h30, 8'h40)},
          fill(8'hAB), '1);
    apply("R5 drain", '0, fill(8'h00), '1);

    while (exp_q.size() > 0) @(negedge clk);

    // R1 reset overrides a writing word
    @(negedge clk);
    instr = {mk(1, 4'd3, 4'd3, 8'h11, 8'h22), mk(1, 4'd5, 4'd6, 8'h33, 8'h44)};
    src_data = fill(8'hCC); src_ready = '1; rst = 1'b1;
    @(posedge clk);
    #2 check_clear("R1 reset during traffic");
    @(negedge clk) rst = 1'b0; instr = '0;
    repeat (2) @(posedge clk);
    finish_run();
  end
endmodule